// File: doc/BRIEF.md
# Instruction-Fetch Address Trap Controller

This block watches the CPU's instruction-fetch bus and flags any fetch from a region where code must never run. Each fetch address falls into one of four classes: internal RAM, the special-function-register (SFR) area, the debug register area, or other memory. The bounds of each region are set by parameters.

A fetch from the SFR area or the debug area always traps. A fetch from internal RAM traps only while the effective RAM-trap enable is set. That enable is armed in two steps. First a pending value is written into the control register, then a key byte is written into the companion code register. Software that runs code from RAM clears the enable by this sequence.

A trap raises one of two requests, chosen by an action bit. One is a single-cycle non-maskable interrupt request. The other is a reset request held for a set number of cycles. The code register also turns two watchdog command bytes into one-cycle pulses for an external watchdog counter.

Top module: `fetch_trap_ctrl`

## Requirements
- R1: After reset the trap outputs and the watchdog pulses are low. The effective RAM-trap enable, its pending copy and the action bit all start at 1, so a RAM fetch traps as a reset request.
- R2: A valid fetch from the SFR area or the debug area always traps, whatever the RAM-trap enable holds.
- R3: A valid fetch from internal RAM traps only while the effective RAM-trap enable is 1.
- R4: Bit 5 of a write to the control register (address 0x34) updates only the pending enable. The effective enable takes the pending value on the clock edge of a write of 0xD2 to the code register (address 0x35).
- R5: A write of any byte other than 0xD2 to the code register leaves the effective RAM-trap enable unchanged.
- R6: Bit 4 of the control register takes effect at once on its write. With bit 4 at 0 a trap raises the interrupt output. With bit 4 at 1 it raises the reset output for exactly RST_HOLD consecutive cycles, starting one clock after the fetch.
- R7: The interrupt output is high for one cycle per trapping fetch, one clock after that fetch. Back-to-back trapping fetches give back-to-back high cycles.
- R8: Writing 0x4E to the code register pulses wdt_clear_o for one cycle. Writing 0xB1 pulses wdt_disable_o for one cycle. Each pulse appears one clock after the write. Other bytes give no pulse.
- R9: A fetch address with fetch_valid_i low never traps. An address outside all three regions never traps.
- R10: Writes to any address other than 0x34 or 0x35 change no state and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | CPU register write strobe |
| wr_addr_i | input | ADDR_W | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| fetch_valid_i | input | 1 | Qualifies fetch_addr_i as an instruction fetch |
| fetch_addr_i | input | ADDR_W | Instruction fetch address |
| trap_irq_o | output | 1 | Non-maskable trap interrupt request pulse |
| trap_rst_o | output | 1 | Trap reset request, held RST_HOLD cycles |
| wdt_clear_o | output | 1 | Watchdog counter clear pulse |
| wdt_disable_o | output | 1 | Watchdog disable pulse |

## Verification
Every result is registered one stage deep. The interrupt pulse, the start of the reset request and the watchdog pulses are all due at the first clock edge after the fetch or write that causes them. The reset request then stays high for RST_HOLD cycles and drops on the next cycle. The bench drives each stimulus for one cycle and samples on the falling edge that follows the next rising edge. It then samples again on each later falling edge to confirm the pulse width or the hold length. A register write shows its effect on the fetch that follows it, so the bench checks the key sequence by sweeping every address of a 10-bit space after each arming step.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

  typedef enum logic [1:0] {
    REGION_OTHER = 2'd0,
    REGION_RAM   = 2'd1,
    REGION_SFR   = 2'd2,
    REGION_DBG   = 2'd3
  } region_e;

  localparam logic [7:0] KEY_RAM_ARM  = 8'hD2;
  localparam logic [7:0] CMD_WD_CLEAR = 8'h4E;
  localparam logic [7:0] CMD_WD_OFF   = 8'hB1;

  localparam int RAM_TRAP_BIT = 5;
  localparam int ACTION_BIT   = 4;

  localparam logic [5:0] CTRL_RST_VAL = 6'b111001;

endpackage

// File: rtl/ftc_ctrl_regs.sv
module ftc_ctrl_regs
  import ftc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h34,
  parameter logic [ADDR_W-1:0] CODE_ADDR = 'h35
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              ram_trap_en_o,
  output logic              to_reset_o,
  output logic              wd_clear_o,
  output logic              wd_off_o
);

  logic ctrl_wr, code_wr, arm_wr;
  logic pend_en_q, eff_en_q, action_q;
  logic wd_clear_q, wd_off_q;

  assign ctrl_wr = wr_en_i && (wr_addr_i == CTRL_ADDR);
  assign code_wr = wr_en_i && (wr_addr_i == CODE_ADDR);
  assign arm_wr  = code_wr && (wr_data_i == KEY_RAM_ARM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_en_q <= CTRL_RST_VAL[RAM_TRAP_BIT];
      eff_en_q  <= CTRL_RST_VAL[RAM_TRAP_BIT];
      action_q  <= CTRL_RST_VAL[ACTION_BIT];
    end else begin
      if (ctrl_wr) begin
        pend_en_q <= wr_data_i[RAM_TRAP_BIT];
        action_q  <= wr_data_i[ACTION_BIT];
      end
      // pending value moves only on the key byte
      if (arm_wr) eff_en_q <= pend_en_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_clear_q <= 1'b0;
      wd_off_q   <= 1'b0;
    end else begin
      wd_clear_q <= code_wr && (wr_data_i == CMD_WD_CLEAR);
      wd_off_q   <= code_wr && (wr_data_i == CMD_WD_OFF);
    end
  end

  assign ram_trap_en_o = eff_en_q;
  assign to_reset_o    = action_q;
  assign wd_clear_o    = wd_clear_q;
  assign wd_off_o      = wd_off_q;

  p_key_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == CODE_ADDR && wr_data_i == 8'hD2)
      |=> (ram_trap_en_o == $past(pend_en_q)));

  p_eff_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == CODE_ADDR && wr_data_i == 8'hD2)
      |=> $stable(ram_trap_en_o));

  p_wd_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == CODE_ADDR && wr_data_i == 8'h4E) |=> wd_clear_o);

  p_wd_pulse_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wd_clear_o && wd_off_o));

endmodule

// File: rtl/ftc_region_dec.sv
module ftc_region_dec
  import ftc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SFR_LO = 'h0000,
  parameter logic [ADDR_W-1:0] SFR_HI = 'h003F,
  parameter logic [ADDR_W-1:0] DBG_LO = 'h0F80,
  parameter logic [ADDR_W-1:0] DBG_HI = 'h0FFF,
  parameter logic [ADDR_W-1:0] RAM_LO = 'h0040,
  parameter logic [ADDR_W-1:0] RAM_HI = 'h083F
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o
);

  localparam int NR = 3;
  // slot order = priority: SFR, debug, RAM
  localparam logic [NR*ADDR_W-1:0] LO_V = {RAM_LO, DBG_LO, SFR_LO};
  localparam logic [NR*ADDR_W-1:0] HI_V = {RAM_HI, DBG_HI, SFR_HI};

  logic [NR-1:0] hit;

  for (genvar i = 0; i < NR; i++) begin : g_win
    localparam logic [ADDR_W-1:0] LO = LO_V[i*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] SPAN = HI_V[i*ADDR_W +: ADDR_W] - LO;
    logic [ADDR_W-1:0] off;
    // modular offset keeps the window test free of constant compares
    assign off    = addr_i - LO;
    assign hit[i] = (off <= SPAN);
  end

  always_comb begin
    if (hit[0])      region_o = REGION_SFR;
    else if (hit[1]) region_o = REGION_DBG;
    else if (hit[2]) region_o = REGION_RAM;
    else             region_o = REGION_OTHER;
  end

endmodule

// File: rtl/ftc_trap_out.sv
module ftc_trap_out #(
  parameter int RST_HOLD = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic to_reset_i,
  output logic irq_o,
  output logic rst_req_o
);

  localparam int CNT_W = $clog2(RST_HOLD + 1);

  logic             irq_q;
  logic [CNT_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      irq_q <= hit_i && !to_reset_i;
      if (hit_i && to_reset_i)   hold_q <= CNT_W'(RST_HOLD);
      else if (hold_q != '0)     hold_q <= hold_q - CNT_W'(1);
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = (hold_q != '0);

  p_irq_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(hit_i && !to_reset_i));

  p_rst_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && to_reset_i) |=> rst_req_o);

  p_rst_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(hit_i && to_reset_i));

endmodule

// File: rtl/fetch_trap_ctrl.sv
module fetch_trap_ctrl
  import ftc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h34,
  parameter logic [ADDR_W-1:0] CODE_ADDR = 'h35,
  parameter logic [ADDR_W-1:0] SFR_LO = 'h0000,
  parameter logic [ADDR_W-1:0] SFR_HI = 'h003F,
  parameter logic [ADDR_W-1:0] DBG_LO = 'h0F80,
  parameter logic [ADDR_W-1:0] DBG_HI = 'h0FFF,
  parameter logic [ADDR_W-1:0] RAM_LO = 'h0040,
  parameter logic [ADDR_W-1:0] RAM_HI = 'h083F,
  parameter int RST_HOLD = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              trap_irq_o,
  output logic              trap_rst_o,
  output logic              wdt_clear_o,
  output logic              wdt_disable_o
);

  logic    ram_trap_en, to_reset, trap_hit;
  region_e region;

  ftc_ctrl_regs #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CODE_ADDR(CODE_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .ram_trap_en_o(ram_trap_en), .to_reset_o(to_reset),
    .wd_clear_o(wdt_clear_o), .wd_off_o(wdt_disable_o)
  );

  ftc_region_dec #(
    .ADDR_W(ADDR_W),
    .SFR_LO(SFR_LO), .SFR_HI(SFR_HI),
    .DBG_LO(DBG_LO), .DBG_HI(DBG_HI),
    .RAM_LO(RAM_LO), .RAM_HI(RAM_HI)
  ) u_dec (
    .addr_i(fetch_addr_i), .region_o(region)
  );

  always_comb begin
    unique case (region)
      REGION_SFR, REGION_DBG: trap_hit = fetch_valid_i;
      REGION_RAM:             trap_hit = fetch_valid_i && ram_trap_en;
      default:                trap_hit = 1'b0;
    endcase
  end

  ftc_trap_out #(.RST_HOLD(RST_HOLD)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hit_i(trap_hit), .to_reset_i(to_reset),
    .irq_o(trap_irq_o), .rst_req_o(trap_rst_o)
  );

  p_fixed_trap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && (region == REGION_SFR || region == REGION_DBG))
      |=> (trap_irq_o || trap_rst_o));

  p_no_fetch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> !trap_irq_o);

  p_other_region_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region == REGION_OTHER) |=> !trap_irq_o);

  p_ram_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && region == REGION_RAM && !ram_trap_en) |=> !trap_irq_o);

endmodule

// File: tb/fetch_trap_ctrl_bench.sv
module fetch_trap_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int HOLD = 3;
  localparam int A_CTRL = 'h034, A_CODE = 'h035;
  localparam int S_LO = 'h000, S_HI = 'h03F;
  localparam int D_LO = 'h3C0, D_HI = 'h3FF;
  localparam int M_LO = 'h040, M_HI = 'h13F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, fvalid = 1'b0;
  logic [AW-1:0] waddr = '0, faddr = '0;
  logic [7:0] wdata = '0;
  logic irq, rreq, wclr, wdis;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit m_pend = 1'b1, m_en = 1'b1, m_act = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_trap_ctrl #(
    .ADDR_W(AW), .CTRL_ADDR(AW'(A_CTRL)), .CODE_ADDR(AW'(A_CODE)),
    .SFR_LO(AW'(S_LO)), .SFR_HI(AW'(S_HI)),
    .DBG_LO(AW'(D_LO)), .DBG_HI(AW'(D_HI)),
    .RAM_LO(AW'(M_LO)), .RAM_HI(AW'(M_HI)),
    .RST_HOLD(HOLD)
  ) u_fetch_trap_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(waddr), .wr_data_i(wdata),
    .fetch_valid_i(fvalid), .fetch_addr_i(faddr),
    .trap_irq_o(irq), .trap_rst_o(rreq),
    .wdt_clear_o(wclr), .wdt_disable_o(wdis)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_trap(input int a, input bit v);
    if (!v) return 1'b0;
    if (a >= S_LO && a <= S_HI) return 1'b1;
    if (a >= D_LO && a <= D_HI) return 1'b1;
    if (a >= M_LO && a <= M_HI) return m_en;
    return 1'b0;
  endfunction

  task automatic fetch(input int a, input bit v, input string req);
    bit t;
    t = exp_trap(a, v);
    @(negedge clk); fvalid = v; faddr = AW'(a);
    @(negedge clk); fvalid = 1'b0;
    chk({req, " irq"}, int'(irq), int'(t && !m_act));
    chk({req, " rst"}, int'(rreq), int'(t && m_act));
    if (t && m_act) begin
      for (int k = 1; k < HOLD; k++) begin
        @(negedge clk);
        chk("R6 rst hold", int'(rreq), 1);
      end
      @(negedge clk);
      chk("R6 rst release", int'(rreq), 0);
    end else if (t) begin
      @(negedge clk);
      chk("R7 irq single", int'(irq), 0);
    end
  endtask

  task automatic wr(input int a, input int d, input string req);
    @(negedge clk); wr_en = 1'b1; waddr = AW'(a); wdata = 8'(d);
    @(negedge clk); wr_en = 1'b0;
    chk({req, " R8 clear"}, int'(wclr), int'(a == A_CODE && d == 'h4E));
    chk({req, " R8 disable"}, int'(wdis), int'(a == A_CODE && d == 'hB1));
    if (a == A_CTRL) begin m_pend = d[5]; m_act = d[4]; end
    if (a == A_CODE && d == 'hD2) m_en = m_pend;
    @(negedge clk);
    chk("R8 pulse width", int'(wclr | wdis), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq reset", int'(irq), 0);
    chk("R1 rst reset", int'(rreq), 0);
    chk("R1 wd reset", int'(wclr | wdis), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: defaults trap RAM fetches as reset requests
    fetch(M_LO + 5, 1'b1, "R1 default RAM trap");
    fetch(S_LO, 1'b1, "R2 default SFR");

    // R2 R3 R6 R9: full sweep under each enable/action pair
    for (int cfg = 0; cfg < 4; cfg++) begin
      wr(A_CTRL, ((cfg & 1) << 5) | ((cfg >> 1) << 4), "R4 ctrl");
      wr(A_CODE, 'hD2, "R4 arm");
      for (int a = 0; a < (1 << AW); a++) fetch(a, 1'b1, "R2/R3 sweep");
      for (int a = 0; a < (1 << AW); a += 7) fetch(a, 1'b0, "R9 no valid");
    end

    // R4 R5: pending value, non-key codes
    wr(A_CTRL, 'h20, "R4 set");
    wr(A_CODE, 'hD2, "R4 arm on");
    wr(A_CTRL, 'h00, "R4 pend off");
    fetch(M_HI, 1'b1, "R4 pending not live");
    wr(A_CODE, 'h4E, "R5 clear code");
    fetch(M_LO, 1'b1, "R5 after 4E");
    wr(A_CODE, 'hB1, "R5 disable code");
    fetch(M_LO, 1'b1, "R5 after B1");
    for (int d = 0; d < 256; d += 17) if (d != 'hD2) wr(A_CODE, d, "R5 other");
    fetch(M_LO + 1, 1'b1, "R5 after others");
    // R10: key to a neighbouring address does nothing
    wr(A_CODE + 1, 'hD2, "R10 wrong addr");
    wr(A_CTRL - 1, 'h4E, "R10 wrong addr code");
    fetch(M_LO + 2, 1'b1, "R10 still armed");
    wr(A_CODE, 'hD2, "R4 arm off");
    fetch(M_LO + 2, 1'b1, "R4 disarmed");
    fetch(D_HI, 1'b1, "R2 debug while disarmed");

    // R7: back-to-back trapping fetches
    @(negedge clk); fvalid = 1'b1; faddr = AW'(S_HI);
    @(negedge clk); faddr = AW'(D_LO);
    chk("R7 b2b first", int'(irq), 1);
    @(negedge clk); fvalid = 1'b0;
    chk("R7 b2b second", int'(irq), 1);
    @(negedge clk);
    chk("R7 b2b end", int'(irq), 0);

    // R6: retrigger during hold restarts the count
    wr(A_CTRL, 'h10, "R6 reset action");
    @(negedge clk); fvalid = 1'b1; faddr = AW'(S_LO);
    @(negedge clk); fvalid = 1'b0;
    @(negedge clk); fvalid = 1'b1;
    @(negedge clk); fvalid = 1'b0;
    for (int k = 0; k < HOLD; k++) begin
      chk("R6 retrigger hold", int'(rreq), 1);
      @(negedge clk);
    end
    chk("R6 retrigger release", int'(rreq), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule